// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block produces the word address for a pipelined synchronous burst memory. On a clock edge where an address strobe is accepted it captures the full external address. After that, each edge with the step input low moves the two least significant bits to the next beat of a four-beat burst. The upper bits never change until the next load.

Two strobes start a burst, and they are gated differently. The processor-side strobe counts only while the master enable is active; with the master enable inactive it is simply not seen. The controller-side strobe is always seen. A strobe that is seen while any of the three enables is inactive gives a deselect cycle: nothing is loaded and the burst position is held. A static order input picks the beat order. Held high, beat n sits at the starting low bits XOR n. Held low, it sits at the starting low bits plus n, wrapping within the four-word block.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, addr_o reads 0 and load_o reads 0.
- R2: strb_ctl_n low on an edge with en_main_n low, en_pos high and en_neg_n low loads addr_i. After that edge, addr_o equals the captured address and load_o is 1.
- R3: strb_cpu_n low on an edge with all three enables active loads addr_i in the same way as R2.
- R4: strb_cpu_n low while en_main_n is high is ignored, provided strb_ctl_n is high. No load happens, load_o is 0, and step_n acts as on an ordinary cycle.
- R5: A strobe that is seen while an enable is inactive gives a deselect cycle. That is strb_ctl_n low, or strb_cpu_n low with en_main_n low. addr_o is held and load_o is 0, whatever step_n is.
- R6: With no strobe seen and step_n low, the burst moves one beat forward after the edge, and load_o is 0.
- R7: With no strobe seen and step_n high, addr_o is held (wait state).
- R8: With order_ilv = 1, beat n (n = 0..3) puts the low two bits at start XOR n.
- R9: With order_ilv = 0, beat n puts the low two bits at (start + n) mod 4.
- R10: A load takes priority over step_n and restarts the burst at beat 0.
- R11: After beat 3, a further step returns to beat 0 of the same block. Bits above the low two never change between loads, even when the linear sum overflows.
- R12: order_ilv is used directly, without a register. Changing it changes addr_o in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | External start address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low, gated by en_main_n |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| en_main_n | input | 1 | Master enable, active low |
| en_pos | input | 1 | Secondary enable, active high |
| en_neg_n | input | 1 | Secondary enable, active low |
| step_n | input | 1 | Burst step, active low |
| order_ilv | input | 1 | Static order select: 1 XOR order, 0 add order |
| addr_o | output | ADDR_W | Current burst address |
| load_o | output | 1 | The last edge accepted a strobe |

## Verification
The bench starts bursts at low bits that expose the difference between the two orders. One is a linear burst from low bits 11, where a sequencer that let the sum carry would corrupt the upper address. Another is a four-step run that must wrap, not stop or spill into the next block. It drives a processor strobe with the master enable off while stepping: a design that gated both strobes the same way would reload or freeze instead of advancing. Each secondary enable is then dropped under a strobe, where a wrong design would load or step. A strobe during a step must restart the burst at beat 0, and flipping the order pin without a clock edge must move the address at once.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam int ADDR_W_DEF = 18;
    localparam int LOW_W_DEF  = 2;

    // What a single clock edge does to the burst state
    typedef enum logic [2:0] {
        CYC_HOLD  = 3'd0,
        CYC_STEP  = 3'd1,
        CYC_LOAD  = 3'd2,
        CYC_DESEL = 3'd3
    } cyc_e;

endpackage

// File: rtl/bsq_gate.sv
module bsq_gate
    import bsq_pkg::*;
(
    input  logic strb_cpu_n,
    input  logic strb_ctl_n,
    input  logic en_main_n,
    input  logic en_pos,
    input  logic en_neg_n,
    input  logic step_n,
    output cyc_e kind_o
);

    logic cpu_seen;
    logic ctl_seen;
    logic any_seen;
    logic all_en;

    always_comb begin
        // processor strobe is invisible without the master enable
        cpu_seen = !strb_cpu_n && !en_main_n;
        ctl_seen = !strb_ctl_n;
        any_seen = cpu_seen || ctl_seen;
        all_en   = !en_main_n && en_pos && !en_neg_n;

        if (any_seen && all_en) begin
            kind_o = CYC_LOAD;
        end else if (any_seen) begin
            kind_o = CYC_DESEL;
        end else if (!step_n) begin
            kind_o = CYC_STEP;
        end else begin
            kind_o = CYC_HOLD;
        end
    end

    // R4: masked processor strobe never yields a load or a deselect on its own
    always_comb begin
        if (en_main_n && strb_ctl_n) begin
            assert (kind_o == CYC_STEP || kind_o == CYC_HOLD)
                else $error("p_cpu_masked_r4");
        end
    end

endmodule

// File: rtl/bsq_order.sv
module bsq_order #(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start_i,
    input  logic [LOW_W-1:0] beat_i,
    input  logic             ilv_i,
    output logic [LOW_W-1:0] lo_o
);

    logic [LOW_W-1:0] lin_lo;
    logic [LOW_W-1:0] xor_lo;

    // ripple sum kept inside the block, the top carry is dropped
    logic [LOW_W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < LOW_W; i++) begin : g_bit
        assign xor_lo[i]   = start_i[i] ^ beat_i[i];
        assign lin_lo[i]   = start_i[i] ^ beat_i[i] ^ carry[i];
        assign carry[i+1]  = (start_i[i] & beat_i[i]) | (carry[i] & (start_i[i] ^ beat_i[i]));
    end

    assign lo_o = ilv_i ? xor_lo : lin_lo;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int LOW_W  = LOW_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              en_main_n,
    input  logic              en_pos,
    input  logic              en_neg_n,
    input  logic              step_n,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] addr_o,
    output logic              load_o
);

    localparam int HI_W = ADDR_W - LOW_W;
    localparam logic [LOW_W-1:0] BEAT_ONE = LOW_W'(1);

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [LOW_W-1:0] start;
        logic [LOW_W-1:0] beat;
        logic             load;
    } st_t;

    st_t  st_d;
    st_t  st_q;
    cyc_e kind;
    logic [LOW_W-1:0] lo;

    bsq_gate u_gate (
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .en_main_n  (en_main_n),
        .en_pos     (en_pos),
        .en_neg_n   (en_neg_n),
        .step_n     (step_n),
        .kind_o     (kind)
    );

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        unique case (kind)
            CYC_LOAD: begin
                st_d.hi    = addr_i[ADDR_W-1:LOW_W];
                st_d.start = addr_i[LOW_W-1:0];
                st_d.beat  = '0;
                st_d.load  = 1'b1;
            end
            CYC_STEP: begin
                st_d.beat = st_q.beat + BEAT_ONE;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bsq_order #(.LOW_W(LOW_W)) u_order (
        .start_i (st_q.start),
        .beat_i  (st_q.beat),
        .ilv_i   (order_ilv),
        .lo_o    (lo)
    );

    assign addr_o = {st_q.hi, lo};
    assign load_o = st_q.load;

    // R2: controller strobe with every enable active captures the address
    p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && !en_main_n && en_pos && !en_neg_n)
        |=> (load_o && addr_o == $past(addr_i)));

    // R3: processor strobe with every enable active captures the address
    p_cpu_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu_n && !en_main_n && en_pos && !en_neg_n)
        |=> (load_o && addr_o == $past(addr_i)));

    // R5: a seen strobe with a missing enable holds the burst state
    p_desel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_DESEL)
        |=> (!load_o && $stable(st_q.beat) && $stable(st_q.start) && $stable(st_q.hi)));

    // R6: a step advances the beat by one
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_ctl_n && (strb_cpu_n || en_main_n) && !step_n)
        |=> (!load_o && st_q.beat == ($past(st_q.beat) + BEAT_ONE)));

    // R7: wait state holds the position
    p_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_ctl_n && (strb_cpu_n || en_main_n) && step_n)
        |=> ($stable(st_q.beat) && $stable(st_q.start) && $stable(st_q.hi)));

    // R10: a load restarts at beat 0 even while stepping
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_LOAD) |=> (st_q.beat == '0));

    // R11: upper bits move only on a load
    p_upper_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != CYC_LOAD) |=> $stable(addr_o[ADDR_W-1:LOW_W]));

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [17:0] addr_i;
    logic        strb_cpu_n, strb_ctl_n, en_main_n, en_pos, en_neg_n, step_n, order_ilv;
    logic [17:0] addr_o;
    logic        load_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .en_main_n(en_main_n), .en_pos(en_pos), .en_neg_n(en_neg_n),
        .step_n(step_n), .order_ilv(order_ilv),
        .addr_o(addr_o), .load_o(load_o)
    );

    function automatic logic [17:0] beat_addr(input logic [17:0] a, input int n, input bit ilv);
        logic [1:0] lo;
        lo = ilv ? (a[1:0] ^ 2'(n)) : (a[1:0] + 2'(n));
        return {a[17:2], lo};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; step_n = 1'b1;
        en_main_n = 1'b0; en_pos = 1'b1; en_neg_n = 1'b0;
    endtask

    task automatic load_ctl(input logic [17:0] a);
        idle(); addr_i = a; strb_ctl_n = 1'b0;
        cyc();
        idle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(); addr_i = 18'h3FFFF; order_ilv = 1'b1;
        cyc(); cyc();
        chk("R1 addr", 32'(addr_o), 32'h0);
        chk("R1 load", 32'(load_o), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_interleave();
        logic [17:0] a = 18'h2A5B6;
        order_ilv = 1'b1;
        load_ctl(a);
        chk("R2 addr", 32'(addr_o), 32'(a));
        chk("R2 load", 32'(load_o), 32'h1);
        step_n = 1'b0;
        for (int n = 1; n <= 4; n++) begin
            cyc();
            chk(n == 4 ? "R11 wrap" : "R8 beat", 32'(addr_o), 32'(beat_addr(a, n, 1'b1)));
            chk("R6 load low", 32'(load_o), 32'h0);
        end
        idle();
    endtask

    task automatic t_linear();
        logic [17:0] a = 18'h10003;
        order_ilv = 1'b0;
        idle(); addr_i = a; strb_cpu_n = 1'b0;
        cyc();
        chk("R3 addr", 32'(addr_o), 32'(a));
        chk("R3 load", 32'(load_o), 32'h1);
        idle(); step_n = 1'b0;
        for (int n = 1; n <= 5; n++) begin
            cyc();
            chk("R9 beat", 32'(addr_o), 32'(beat_addr(a, n, 1'b0)));
            chk("R11 upper", 32'(addr_o[17:2]), 32'(a[17:2]));
        end
        idle();
    endtask

    task automatic t_suspend();
        logic [17:0] a = 18'h00401;
        order_ilv = 1'b1;
        load_ctl(a);
        step_n = 1'b0; cyc();
        chk("R6 step", 32'(addr_o), 32'(beat_addr(a, 1, 1'b1)));
        step_n = 1'b1;
        for (int k = 0; k < 2; k++) begin
            cyc();
            chk("R7 wait", 32'(addr_o), 32'(beat_addr(a, 1, 1'b1)));
        end
        step_n = 1'b0; cyc();
        chk("R7 resume", 32'(addr_o), 32'(beat_addr(a, 2, 1'b1)));
        idle();
    endtask

    task automatic t_masked();
        logic [17:0] a = 18'h3FFF2;
        order_ilv = 1'b1;
        load_ctl(a);
        addr_i = 18'h00000; en_main_n = 1'b1; strb_cpu_n = 1'b0; step_n = 1'b0;
        cyc();
        chk("R4 steps", 32'(addr_o), 32'(beat_addr(a, 1, 1'b1)));
        chk("R4 no load", 32'(load_o), 32'h0);
        step_n = 1'b1;
        cyc();
        chk("R4 holds", 32'(addr_o), 32'(beat_addr(a, 1, 1'b1)));
        idle();
    endtask

    task automatic t_desel();
        logic [17:0] a = 18'h12345;
        order_ilv = 1'b0;
        load_ctl(a);
        step_n = 1'b0; cyc();
        addr_i = 18'h0F0F0;
        // controller strobe, positive enable off
        idle(); strb_ctl_n = 1'b0; en_pos = 1'b0; step_n = 1'b0; cyc();
        chk("R5 en_pos", 32'(addr_o), 32'(beat_addr(a, 1, 1'b0)));
        chk("R5 load", 32'(load_o), 32'h0);
        // controller strobe, master enable off
        idle(); strb_ctl_n = 1'b0; en_main_n = 1'b1; step_n = 1'b0; cyc();
        chk("R5 en_main", 32'(addr_o), 32'(beat_addr(a, 1, 1'b0)));
        // processor strobe, negative enable off
        idle(); strb_cpu_n = 1'b0; en_neg_n = 1'b1; step_n = 1'b0; cyc();
        chk("R5 en_neg", 32'(addr_o), 32'(beat_addr(a, 1, 1'b0)));
        chk("R5 load2", 32'(load_o), 32'h0);
        idle(); step_n = 1'b0; cyc();
        chk("R5 intact", 32'(addr_o), 32'(beat_addr(a, 2, 1'b0)));
        idle();
    endtask

    task automatic t_priority();
        logic [17:0] a = 18'h0550A;
        logic [17:0] b = 18'h2AAF7;
        order_ilv = 1'b1;
        load_ctl(a);
        step_n = 1'b0; cyc(); cyc();
        addr_i = b; strb_ctl_n = 1'b0; cyc();
        chk("R10 reload", 32'(addr_o), 32'(b));
        chk("R10 load", 32'(load_o), 32'h1);
        strb_ctl_n = 1'b1; cyc();
        chk("R10 beat1", 32'(addr_o), 32'(beat_addr(b, 1, 1'b1)));
        idle();
    endtask

    task automatic t_mode_live();
        logic [17:0] a = 18'h0AAA9;
        order_ilv = 1'b1;
        load_ctl(a);
        step_n = 1'b0; cyc(); idle();
        chk("R12 ilv", 32'(addr_o), 32'(beat_addr(a, 1, 1'b1)));
        #0.5 order_ilv = 1'b0;
        #0.5;
        chk("R12 lin", 32'(addr_o), 32'(beat_addr(a, 1, 1'b0)));
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_interleave();
        t_linear();
        t_suspend();
        t_masked();
        t_desel();
        t_priority();
        t_mode_live();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule